// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block gives a host a path into a 32-bit internal register space through a small window of 64-bit memory-mapped registers. To start an access, the host writes one 64-bit command word. That word packs an opcode, a 13-bit internal address and 32 bits of write data. The bridge then runs a single read or write on a simple internal register bus. When the access ends, it raises a valid flag in a status word, and for a read it places the returned data beside that flag. The host polls the status word until the flag is set.

A read-only descriptor word reports how the attached serial peripheral master is set up. It carries the shift order, word width, chip-select count, clock polarity and clock phase, plus a 16-bit peripheral identifier. All of these are fixed by parameters. Host reads of the window are combinational on the address. Host writes are taken on the clock edge on which request and write enable are both high.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, the status word reads zero (valid 0, error 0, read data 0) and no internal request is issued.
- R2: The word at byte offset 0x08 reads back the descriptor: bit 1 shift order (1 = LSB first), bits 7:2 word width, bits 13:8 chip-select count, bit 14 clock polarity, bit 15 clock phase, bits 47:32 peripheral identifier, and all other bits zero.
- R3: A host write to offset 0x10 while idle carries write data in bits 31:0, address in bits 44:32 and opcode in bits 63:62, where 1 is read and 2 is write. For opcode 1 or 2, the internal request is high for exactly the one cycle after that edge, with the address, write enable (1 only for opcode 2) and write data taken from the command.
- R4: The word at offset 0x18 returns read data in bits 31:0, the valid flag in bit 32 and the sticky error flag in bit 33, with all other bits zero.
- R5: An accepted read or write command clears the valid flag from the next cycle onward. The flag is set again in the cycle after the acknowledge. A read loads the acknowledged data into bits 31:0 at that same point, and a write leaves the read data unchanged.
- R6: Opcodes 0 and 3 issue no internal request and show valid set in the very next cycle.
- R7: The acknowledge may arrive in the request cycle or any number of cycles later, and the command always completes once it does. An acknowledge while no command is outstanding changes nothing.
- R8: A command written while another is outstanding is dropped: no request, no change to the outstanding access. It sets the error flag, which then stays set until reset.
- R9: Host writes to offsets 0x08, 0x18 and 0x00 have no effect. Offsets 0x10 and 0x00 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | HOST_AW | Host byte offset |
| host_wdata_i | input | 64 | Host write data |
| host_rdata_o | output | 64 | Host read data for the addressed word |
| ibus_req_o | output | 1 | Internal bus request, one-cycle pulse |
| ibus_we_o | output | 1 | Internal bus write enable |
| ibus_addr_o | output | 13 | Internal register address |
| ibus_wdata_o | output | 32 | Internal write data |
| ibus_ack_i | input | 1 | Internal bus acknowledge |
| ibus_rdata_i | input | 32 | Internal read data, valid with the acknowledge |

## Verification
A fault in the outstanding-command state shows up within one cycle of the next host command. A stuck busy condition turns a valid command into a dropped one that raises the error bit. A lost busy condition lets a second request pulse onto the internal bus. A wrong read-pending flag becomes visible in status bits 31:0 in the cycle after the acknowledge, because a write would overwrite the read data or a read would leave it stale. The bench compares the status word, the descriptor and the internal request fields against a behavioural model on every cycle. Any divergence is therefore reported on the cycle it first appears at the ports.

// File: rtl/ireg_bridge_pkg.sv
`timescale 1ns/100ps
package ireg_bridge_pkg;
  localparam int HOST_DW      = 64;
  localparam int IREG_AW      = 13;
  localparam int IREG_DW      = 32;
  localparam int CTL_ADDR_LSB = 32;
  localparam int CTL_OP_LSB   = 62;
  localparam int STAT_VLD_BIT = 32;
  localparam int STAT_ERR_BIT = 33;
  localparam int WIN_LSB      = 3;
  localparam int WIN_AW       = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } ireg_op_e;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_PARAM = 2'd1,
    WIN_CTRL  = 2'd2,
    WIN_STAT  = 2'd3
  } win_sel_e;

  typedef struct packed {
    ireg_op_e             op;
    logic [IREG_AW-1:0]   addr;
    logic [IREG_DW-1:0]   wdata;
  } ireg_cmd_t;
endpackage

// File: rtl/ireg_host_regs.sv
`timescale 1ns/100ps
module ireg_host_regs
  import ireg_bridge_pkg::*;
#(
  parameter int          HOST_AW    = 5,
  parameter bit          LSB_FIRST  = 1'b0,
  parameter int          WORD_BITS  = 32,
  parameter int          NUM_CS     = 1,
  parameter bit          CPOL       = 1'b0,
  parameter bit          CPHA       = 1'b0,
  parameter logic [15:0] PERIPH_ID  = 16'h0A31
) (
  input  logic                host_req_i,
  input  logic                host_we_i,
  input  logic [HOST_AW-1:0]  host_addr_i,
  input  logic [HOST_DW-1:0]  host_wdata_i,
  output logic [HOST_DW-1:0]  host_rdata_o,
  output logic                ctrl_wr_o,
  output ireg_cmd_t           ctrl_cmd_o,
  input  logic                stat_valid_i,
  input  logic                stat_err_i,
  input  logic [IREG_DW-1:0]  stat_rdata_i
);
  localparam logic [HOST_DW-1:0] PARAM_WORD =
      (64'(LSB_FIRST) << 1) |
      (64'(WORD_BITS & 63) << 2) |
      (64'(NUM_CS & 63) << 8) |
      (64'(CPOL) << 14) |
      (64'(CPHA) << 15) |
      (64'(PERIPH_ID) << 32);

  logic     hi_ok;
  win_sel_e sel;

  generate
    if (HOST_AW > WIN_AW) begin : g_wide
      assign hi_ok = ~|host_addr_i[HOST_AW-1:WIN_AW];
    end else begin : g_narrow
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign sel = hi_ok ? win_sel_e'(host_addr_i[WIN_AW-1:WIN_LSB]) : WIN_NONE;

  always_comb begin
    host_rdata_o = '0;
    case (sel)
      WIN_PARAM: host_rdata_o = PARAM_WORD;
      WIN_STAT: begin
        host_rdata_o[IREG_DW-1:0]  = stat_rdata_i;
        host_rdata_o[STAT_VLD_BIT] = stat_valid_i;
        host_rdata_o[STAT_ERR_BIT] = stat_err_i;
      end
      default: host_rdata_o = '0;
    endcase
  end

  assign ctrl_wr_o        = host_req_i & host_we_i & (sel == WIN_CTRL);
  assign ctrl_cmd_o.op    = ireg_op_e'(host_wdata_i[HOST_DW-1:CTL_OP_LSB]);
  assign ctrl_cmd_o.addr  = host_wdata_i[CTL_ADDR_LSB+IREG_AW-1:CTL_ADDR_LSB];
  assign ctrl_cmd_o.wdata = host_wdata_i[IREG_DW-1:0];

  logic unused_bits;
  assign unused_bits = ^{host_wdata_i[CTL_OP_LSB-1:CTL_ADDR_LSB+IREG_AW],
                         host_addr_i[WIN_LSB-1:0]};
endmodule

// File: rtl/ireg_cmd_seq.sv
`timescale 1ns/100ps
module ireg_cmd_seq
  import ireg_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  ireg_cmd_t          ctrl_cmd_i,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [IREG_DW-1:0] done_rdata_i,
  output logic               launch_o,
  output logic               valid_o,
  output logic               err_o,
  output logic [IREG_DW-1:0] rdata_o
);
  logic               accept;
  logic               bus_op;
  logic               valid_q, err_q, rd_pend_q;
  logic [IREG_DW-1:0] rdata_q;

  assign accept   = ctrl_wr_i & ~busy_i;
  assign bus_op   = (ctrl_cmd_i.op == OP_READ) || (ctrl_cmd_i.op == OP_WRITE);
  assign launch_o = accept & bus_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (ctrl_wr_i && busy_i) err_q <= 1'b1;
      if (accept) valid_q <= ~bus_op;
      if (launch_o) rd_pend_q <= (ctrl_cmd_i.op == OP_READ);
      if (done_i) begin
        valid_q <= 1'b1;
        if (rd_pend_q) rdata_q <= done_rdata_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  // R5: completion flag never shows while an access is outstanding
  assert_valid_low_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !valid_q) else $error("valid set while busy");

  // R5: read data only moves on a completion
  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(rdata_q)) else $error("read data moved without ack");

  // R8: error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q) else $error("error flag dropped");
endmodule

// File: rtl/ireg_bus_master.sv
`timescale 1ns/100ps
module ireg_bus_master
  import ireg_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  ireg_cmd_t          cmd_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [IREG_DW-1:0] done_rdata_o,
  output logic               ibus_req_o,
  output logic               ibus_we_o,
  output logic [IREG_AW-1:0] ibus_addr_o,
  output logic [IREG_DW-1:0] ibus_wdata_o,
  input  logic               ibus_ack_i,
  input  logic [IREG_DW-1:0] ibus_rdata_i
);
  logic               req_q, we_q, busy_q;
  logic [IREG_AW-1:0] addr_q;
  logic [IREG_DW-1:0] wdata_q;

  // ack counts from the request cycle on
  assign done_o       = busy_q & ibus_ack_i;
  assign done_rdata_o = ibus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      busy_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= launch_i;
      if (done_o) busy_q <= 1'b0;
      if (launch_i) begin
        busy_q  <= 1'b1;
        we_q    <= (cmd_i.op == OP_WRITE);
        addr_q  <= cmd_i.addr;
        wdata_q <= cmd_i.wdata;
      end
    end
  end

  assign busy_o       = busy_q;
  assign ibus_req_o   = req_q;
  assign ibus_we_o    = we_q;
  assign ibus_addr_o  = addr_q;
  assign ibus_wdata_o = wdata_q;

  // R3: request is a single-cycle pulse
  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o |=> !ibus_req_o) else $error("request longer than one cycle");
endmodule

// File: rtl/ireg_bridge.sv
`timescale 1ns/100ps
module ireg_bridge
  import ireg_bridge_pkg::*;
#(
  parameter int          HOST_AW   = 5,
  parameter bit          LSB_FIRST = 1'b0,
  parameter int          WORD_BITS = 32,
  parameter int          NUM_CS    = 1,
  parameter bit          CPOL      = 1'b0,
  parameter bit          CPHA      = 1'b0,
  parameter logic [15:0] PERIPH_ID = 16'h0A31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [63:0]        host_wdata_i,
  output logic [63:0]        host_rdata_o,
  output logic               ibus_req_o,
  output logic               ibus_we_o,
  output logic [12:0]        ibus_addr_o,
  output logic [31:0]        ibus_wdata_o,
  input  logic               ibus_ack_i,
  input  logic [31:0]        ibus_rdata_i
);
  logic               ctrl_wr, launch, busy, done;
  logic               stat_valid, stat_err;
  logic [IREG_DW-1:0] stat_rdata, done_rdata;
  ireg_cmd_t          ctrl_cmd;

  ireg_host_regs #(
    .HOST_AW(HOST_AW), .LSB_FIRST(LSB_FIRST), .WORD_BITS(WORD_BITS),
    .NUM_CS(NUM_CS), .CPOL(CPOL), .CPHA(CPHA), .PERIPH_ID(PERIPH_ID)
  ) u_regs (
    .host_req_i  (host_req_i),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .ctrl_wr_o   (ctrl_wr),
    .ctrl_cmd_o  (ctrl_cmd),
    .stat_valid_i(stat_valid),
    .stat_err_i  (stat_err),
    .stat_rdata_i(stat_rdata)
  );

  ireg_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_cmd_i  (ctrl_cmd),
    .busy_i      (busy),
    .done_i      (done),
    .done_rdata_i(done_rdata),
    .launch_o    (launch),
    .valid_o     (stat_valid),
    .err_o       (stat_err),
    .rdata_o     (stat_rdata)
  );

  ireg_bus_master u_mst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .cmd_i       (ctrl_cmd),
    .busy_o      (busy),
    .done_o      (done),
    .done_rdata_o(done_rdata),
    .ibus_req_o  (ibus_req_o),
    .ibus_we_o   (ibus_we_o),
    .ibus_addr_o (ibus_addr_o),
    .ibus_wdata_o(ibus_wdata_o),
    .ibus_ack_i  (ibus_ack_i),
    .ibus_rdata_i(ibus_rdata_i)
  );

  // R6: local opcodes complete at once with no bus traffic
  assert_local_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !busy && (ctrl_cmd.op == OP_NONE || ctrl_cmd.op == OP_RSVD))
      |=> (stat_valid && !ibus_req_o)) else $error("local opcode misbehaved");

  // R8: a command that collides with an outstanding one issues nothing
  assert_busy_no_issue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy) |=> !ibus_req_o) else $error("request issued while busy");
endmodule

// File: tb/sim_ireg_bridge.sv
`timescale 1ns/100ps
module sim_ireg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq = 1'b0, hwe = 1'b0;
  logic [4:0]  haddr = 5'h18;
  logic [63:0] hwdata = '0;
  logic [63:0] hrdata;
  logic        req, we;
  logic [12:0] iaddr;
  logic [31:0] iwdata;
  logic        sl_ack = 1'b0, spur_ack = 1'b0;
  logic [31:0] sl_rdata = '0, spur_data = '0;
  logic        ack_w;
  logic [31:0] rdata_w;

  int checks = 0, fails = 0;
  int sl_delay = 0;

  localparam logic [63:0] EXP_PARAM =
    (64'd1 << 1) | (64'd16 << 2) | (64'd3 << 8) | (64'd1 << 14) | (64'hBEEF << 32);

  assign ack_w   = sl_ack | spur_ack;
  assign rdata_w = spur_ack ? spur_data : sl_rdata;

  always #2.5 clk = ~clk;

  ireg_bridge #(
    .HOST_AW(5), .LSB_FIRST(1'b1), .WORD_BITS(16), .NUM_CS(3),
    .CPOL(1'b1), .CPHA(1'b0), .PERIPH_ID(16'hBEEF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(hreq), .host_we_i(hwe), .host_addr_i(haddr),
    .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .ibus_req_o(req), .ibus_we_o(we), .ibus_addr_o(iaddr),
    .ibus_wdata_o(iwdata), .ibus_ack_i(ack_w), .ibus_rdata_i(rdata_w)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // internal register slave with programmable acknowledge delay
  int          mem [int];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic        p_we;
  logic [12:0] p_addr;
  logic [31:0] p_wdata;
  always @(posedge clk) begin
    #1;
    sl_ack = 1'b0;
    if (!rst_n) pend = 1'b0;
    else begin
      if (req) begin
        pend = 1'b1; cnt = sl_delay; p_we = we; p_addr = iaddr; p_wdata = iwdata;
      end
      if (pend) begin
        if (cnt == 0) begin
          sl_ack = 1'b1;
          if (p_we) begin
            mem[int'(p_addr)] = int'(p_wdata);
            sl_rdata = 32'h0;
          end else
            sl_rdata = mem.exists(int'(p_addr)) ? 32'(mem[int'(p_addr)]) : (32'hA5A5_0000 | 32'(p_addr));
          pend = 1'b0;
        end else cnt--;
      end
    end
  end

  // behavioural reference
  logic        m_valid, m_err, m_busy, m_isrd, m_req, m_we;
  logic [31:0] m_rdata, m_wdata;
  logic [12:0] m_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_err = 0; m_busy = 0; m_isrd = 0; m_req = 0; m_we = 0;
      m_rdata = 0; m_wdata = 0; m_addr = 0;
    end else begin
      logic was_busy;
      logic [1:0] op;
      was_busy = m_busy;
      m_req = 0;
      if (was_busy && ack_w) begin
        m_valid = 1; m_busy = 0;
        if (m_isrd) m_rdata = rdata_w;
      end
      if (hreq && hwe && haddr[4:3] == 2'd2) begin
        op = hwdata[63:62];
        if (was_busy) m_err = 1;
        else if (op == 2'd1 || op == 2'd2) begin
          m_busy = 1; m_valid = 0; m_isrd = (op == 2'd1); m_req = 1;
          m_we = (op == 2'd2); m_addr = hwdata[44:32]; m_wdata = hwdata[31:0];
        end else m_valid = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [63:0] exp_rd;
      case (haddr[4:3])
        2'd1: exp_rd = EXP_PARAM;
        2'd3: exp_rd = {30'd0, m_err, m_valid, m_rdata};
        default: exp_rd = '0;
      endcase
      chk(haddr[4:3] == 2'd1 ? "R2 descriptor" : haddr[4:3] == 2'd3 ? "R4 status" : "R9 zero word",
          hrdata, exp_rd);
      chk("R3 request strobe", 64'(req), 64'(m_req));
      if (m_req) chk("R3 request fields", {18'd0, iaddr, we, iwdata}, {18'd0, m_addr, m_we, m_wdata});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [63:0] d);
    hreq = 1; hwe = 1; haddr = a; hwdata = d;
    tick();
    hreq = 0; hwe = 0;
  endtask

  task automatic peek(input logic [4:0] a);
    haddr = a; #0.5;
  endtask

  task automatic wait_valid(input string tag);
    bit seen = 0;
    haddr = 5'h18;
    for (int i = 0; i < 60; i++) begin
      #0.5;
      if (hrdata[32]) begin seen = 1; break; end
      tick();
    end
    chk(tag, 64'(seen), 64'd1);
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] x;
    do_reset();
    // R1 reset state
    peek(5'h18); chk("R1 status after reset", hrdata, 64'h0);
    chk("R1 no request after reset", 64'(req), 64'd0);
    // R6 opcode 0 completes locally
    host_wr(5'h10, 64'h0000_0010_1234_5678);
    chk("R6 no request for opcode 0", 64'(req), 64'd0);
    peek(5'h18); chk("R6 valid after opcode 0", hrdata, 64'h1_0000_0000);
    // R2 descriptor
    peek(5'h08); chk("R2 descriptor word", hrdata, EXP_PARAM);
    // R3 write command, ack in request cycle
    sl_delay = 0;
    host_wr(5'h10, 64'h8000_0010_DEAD_BEEF);
    chk("R3 write request fields", {req, we, 3'd0, iaddr, iwdata}, {1'b1, 1'b1, 3'd0, 13'h010, 32'hDEAD_BEEF});
    wait_valid("R7 write completes");
    peek(5'h18); chk("R5 write keeps read data", hrdata, 64'h1_0000_0000);
    // R5 read command with delayed ack
    sl_delay = 3;
    host_wr(5'h10, 64'h4000_0010_0000_0000);
    chk("R3 read request", {req, we, 3'd0, iaddr}, {1'b1, 1'b0, 3'd0, 13'h010});
    peek(5'h18); chk("R5 valid cleared", 64'(hrdata[32]), 64'd0);
    wait_valid("R7 delayed read completes");
    chk("R5 read data loaded", hrdata, 64'h1_DEAD_BEEF);
    // R8 collision
    sl_delay = 6;
    host_wr(5'h10, 64'h4000_0030_0000_0000);
    tick();
    host_wr(5'h10, 64'h8000_0020_0000_0001);
    chk("R8 no request on collision", 64'(req), 64'd0);
    wait_valid("R7 outstanding read completes");
    chk("R8 error set, read intact", hrdata, 64'h3_A5A5_0030);
    sl_delay = 0;
    host_wr(5'h10, 64'h4000_0020_0000_0000);
    wait_valid("R8 follow-up read");
    chk("R8 dropped write left no trace", hrdata, 64'h3_A5A5_0020);
    // R9 writes to other words
    host_wr(5'h18, '1); host_wr(5'h08, '1); host_wr(5'h00, 64'h8000_0020_0000_0009);
    chk("R9 no request from other words", 64'(req), 64'd0);
    peek(5'h18); chk("R9 status untouched", hrdata, 64'h3_A5A5_0020);
    peek(5'h08); chk("R9 descriptor untouched", hrdata, EXP_PARAM);
    peek(5'h10); chk("R9 control reads zero", hrdata, 64'h0);
    peek(5'h00); chk("R9 offset 0 reads zero", hrdata, 64'h0);
    // R7 stray acknowledge
    spur_data = 32'h0BAD_F00D; spur_ack = 1; tick(); spur_ack = 0; tick();
    peek(5'h18); chk("R7 stray ack ignored", hrdata, 64'h3_A5A5_0020);
    // mixed traffic against the model
    x = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      sl_delay = int'(x[10:8]) % 5;
      host_wr(5'h10, {x[1:0], 17'd0, 7'd0, x[7:4], 2'b00, x});
      if (x[12]) begin tick(); host_wr(5'h10, {2'd2, 17'd0, 13'h004, ~x}); end
      wait_valid("R7 mixed traffic completes");
      tick();
    end
    // R8 error cleared by reset, R6 opcode 3
    do_reset();
    peek(5'h18); chk("R8 error cleared by reset", hrdata, 64'h0);
    host_wr(5'h10, 64'hC000_0004_0000_0055);
    chk("R6 no request for opcode 3", 64'(req), 64'd0);
    peek(5'h18); chk("R6 valid after opcode 3", hrdata, 64'h1_0000_0000);
    repeat (3) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule